// File: doc/BRIEF.md
# Floating-Point Add/Subtract Unit

This block adds or subtracts two single-precision binary floating-point numbers (1 sign bit, 8 exponent bits, 23 fraction bits by default, sizes set by parameters). The caller presents both operands and an operation select and pulses `start_i`. The unit then runs through a short sequence of states. It restores the hidden leading ones, orders the operands by magnitude and shifts the smaller significand right to line up the exponents. It then adds or subtracts the significands and renormalizes the outcome one bit position per cycle. When the result is ready, `done_o` pulses for one cycle.

Only normal numbers and zero are handled. An exponent field of zero means zero, and the fraction bits are then ignored. Every bit that falls off the low end during alignment or normalization is discarded, so rounding is always toward zero. If the final exponent lands outside the normal range, the unit raises a flag and returns an all-zero word instead of encoding the value. The result and flags stay in their registers until the next operation completes.

Top module: `fp_addsub`

## Requirements
- R1: After synchronous reset, `result_o` is 0, `ovf_o` and `unf_o` are 0, and `done_o` is 0.
- R2: For operands of equal sign under add, the result is {sign, larger exponent, fraction}. The fraction comes from adding the larger significand (hidden 1 restored) to the smaller one shifted right by the exponent difference, with shifted-out bits dropped.
- R3: When the exponent difference is 24 or more, the smaller operand contributes nothing, and an add returns the larger operand unchanged.
- R4: `sub_i`=1 inverts the sign of B (bit 31). When the effective signs differ, the smaller magnitude is subtracted from the larger, and the result carries the sign of the larger magnitude.
- R5: A carry out of the significand sum shifts the significand right by one, dropping its LSB, and increments the exponent.
- R6: A difference with leading zeros is shifted left, one exponent decrement per position, until the hidden-bit position (bit 23 of the significand) is set.
- R7: A zero significand result yields +0 (all 32 bits zero) with both flags clear.
- R8: An operand whose exponent field (bits 30:23) is zero is zero. If A is zero, the result is B with its sign inverted when `sub_i`=1. Otherwise, if B is zero, the result is A unchanged.
- R9: If the normalized exponent is 255 or more, `ovf_o` is set and `result_o` is 0.
- R10: If the normalized exponent falls below 1, `unf_o` is set and `result_o` is 0.
- R11: `done_o` is high for exactly one cycle per operation. `result_o` changes only in a cycle where `done_o` is high, and holds between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| sub_i | input | 1 | 0 = A+B, 1 = A-B |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Result word |
| ovf_o | output | 1 | Exponent overflow |
| unf_o | output | 1 | Exponent underflow |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A sweep of a few thousand pseudo-random operand pairs is compared with an arithmetic model built in the bench. The exponents are kept close together so that partial alignment and both add and subtract paths occur often. Directed pairs then isolate one mechanism each:
- a carry that drops an LSB, which separates truncation from rounding;
- a shift of exactly 23 versus 24, which finds an off-by-one in the zeroing of the smaller operand;
- a multi-position left renormalization;
- an exact cancellation, which must give +0;
- an order where B is the larger magnitude, which exposes a wrong result sign;
- zero operands on each side;
- exponents pushed past both ends of the range.

The done pulse width and the holding of the result are observed separately.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALIGN = 3'd1,
    ST_ADD   = 3'd2,
    ST_NORM  = 3'd3,
    ST_DONE  = 3'd4
  } fpa_state_e;
endpackage

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             sub_i,
  output logic             zero_op_o,
  output logic [W-1:0]     passthru_o,
  output logic [SIG_W-1:0] big_sig_o,
  output logic [SIG_W-1:0] small_sig_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             sign_o,
  output logic             eff_sub_o
);
  logic [EXP_W-1:0] ea, eb, diff;
  logic [SIG_W-1:0] ma, mb, small_raw;
  logic             sa, sb, a_big;

  always_comb begin
    ea = a_i[W-2 -: EXP_W];
    eb = b_i[W-2 -: EXP_W];
    sa = a_i[W-1];
    sb = b_i[W-1] ^ sub_i;
    ma = {1'b1, a_i[MAN_W-1:0]};
    mb = {1'b1, b_i[MAN_W-1:0]};
    // magnitude ordering: exponent first, then significand
    a_big = (ea > eb) || ((ea == eb) && (ma >= mb));
    diff        = a_big ? (ea - eb) : (eb - ea);
    big_sig_o   = a_big ? ma : mb;
    small_raw   = a_big ? mb : ma;
    small_sig_o = small_raw >> diff;
    exp_o       = a_big ? ea : eb;
    sign_o      = a_big ? sa : sb;
    eff_sub_o   = sa ^ sb;
    zero_op_o   = (ea == '0) || (eb == '0);
    passthru_o  = (ea == '0) ? {sb, b_i[W-2:0]} : a_i;
  end
endmodule

// File: rtl/fpa_sig_add.sv
module fpa_sig_add #(
  parameter int MAN_W = 23,
  localparam int SIG_W = MAN_W + 1,
  localparam int SUM_W = SIG_W + 1
) (
  input  logic [SIG_W-1:0] big_i,
  input  logic [SIG_W-1:0] small_i,
  input  logic             sub_i,
  output logic [SUM_W-1:0] sum_o
);
  always_comb begin
    if (sub_i) sum_o = {1'b0, big_i} - {1'b0, small_i};
    else       sum_o = {1'b0, big_i} + {1'b0, small_i};
  end
endmodule

// File: rtl/fpa_norm_step.sv
module fpa_norm_step #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int SUM_W = MAN_W + 2,
  localparam int EW    = EXP_W + 2
) (
  input  logic [SUM_W-1:0]        sig_i,
  input  logic signed [EW-1:0]    exp_i,
  output logic [SUM_W-1:0]        sig_o,
  output logic signed [EW-1:0]    exp_o,
  output logic                    settled_o,
  output logic                    zero_o
);
  always_comb begin
    zero_o    = (sig_i == '0);
    sig_o     = sig_i;
    exp_o     = exp_i;
    settled_o = 1'b0;
    if (sig_i[SUM_W-1]) begin
      // carry out: one right shift, LSB dropped
      sig_o = sig_i >> 1;
      exp_o = exp_i + EW'(1);
    end else if (!sig_i[MAN_W]) begin
      sig_o = sig_i << 1;
      exp_o = exp_i - EW'(1);
    end else begin
      settled_o = 1'b1;
    end
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       sub_i,
  input  logic [EXP_W+MAN_W:0]       a_i,
  input  logic [EXP_W+MAN_W:0]       b_i,
  output logic [EXP_W+MAN_W:0]       result_o,
  output logic                       ovf_o,
  output logic                       unf_o,
  output logic                       done_o
);
  localparam int W       = 1 + EXP_W + MAN_W;
  localparam int SIG_W   = MAN_W + 1;
  localparam int SUM_W   = SIG_W + 1;
  localparam int EW      = EXP_W + 2;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  fpa_state_e state;
  logic [W-1:0]             a_q, b_q;
  logic                     sub_q;
  logic [SIG_W-1:0]         big_q, small_q;
  logic signed [EW-1:0]     exp_q;
  logic                     sign_q, esub_q;
  logic [SUM_W-1:0]         sig_q;

  logic                     al_zero, al_sign, al_esub;
  logic [W-1:0]             al_pass;
  logic [SIG_W-1:0]         al_big, al_small;
  logic [EXP_W-1:0]         al_exp;
  logic [SUM_W-1:0]         add_sum;
  logic [SUM_W-1:0]         nm_sig;
  logic signed [EW-1:0]     nm_exp;
  logic                     nm_settled, nm_zero;

  fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .a_i(a_q), .b_i(b_q), .sub_i(sub_q),
    .zero_op_o(al_zero), .passthru_o(al_pass),
    .big_sig_o(al_big), .small_sig_o(al_small),
    .exp_o(al_exp), .sign_o(al_sign), .eff_sub_o(al_esub)
  );

  fpa_sig_add #(.MAN_W(MAN_W)) u_add (
    .big_i(big_q), .small_i(small_q), .sub_i(esub_q), .sum_o(add_sum)
  );

  fpa_norm_step #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .sig_i(sig_q), .exp_i(exp_q), .sig_o(nm_sig), .exp_o(nm_exp),
    .settled_o(nm_settled), .zero_o(nm_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      sub_q    <= 1'b0;
      big_q    <= '0;
      small_q  <= '0;
      exp_q    <= '0;
      sign_q   <= 1'b0;
      esub_q   <= 1'b0;
      sig_q    <= '0;
      result_o <= '0;
      ovf_o    <= 1'b0;
      unf_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            a_q   <= a_i;
            b_q   <= b_i;
            sub_q <= sub_i;
            state <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          if (al_zero) begin
            result_o <= al_pass;
            ovf_o    <= 1'b0;
            unf_o    <= 1'b0;
            done_o   <= 1'b1;
            state    <= ST_DONE;
          end else begin
            big_q   <= al_big;
            small_q <= al_small;
            exp_q   <= $signed({2'b00, al_exp});
            sign_q  <= al_sign;
            esub_q  <= al_esub;
            state   <= ST_ADD;
          end
        end
        ST_ADD: begin
          sig_q <= add_sum;
          state <= ST_NORM;
        end
        ST_NORM: begin
          if (nm_zero) begin
            result_o <= '0;
            ovf_o    <= 1'b0;
            unf_o    <= 1'b0;
            done_o   <= 1'b1;
            state    <= ST_DONE;
          end else if (nm_settled) begin
            ovf_o  <= (int'(exp_q) >= EXP_MAX);
            unf_o  <= (int'(exp_q) < 1);
            if ((int'(exp_q) >= EXP_MAX) || (int'(exp_q) < 1))
              result_o <= '0;
            else
              result_o <= {sign_q, exp_q[EXP_W-1:0], sig_q[MAN_W-1:0]};
            done_o <= 1'b1;
            state  <= ST_DONE;
          end else begin
            sig_q <= nm_sig;
            exp_q <= nm_exp;
          end
        end
        default: begin
          done_o <= 1'b0;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  // R11: completion strobe lasts a single cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11: the result word moves only together with the strobe
  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> done_o);

  // R4: the subtrahend never exceeds the minuend after ordering
  p_order_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADD) |-> (big_q >= small_q));

  // R9 / R10: a flagged result is the all-zero word, never both flags
  p_flag_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_o || unf_o) |-> (result_o == '0));
  p_flag_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && unf_o));

  // R6: a settled significand always has its hidden bit set
  p_norm_lead_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NORM && nm_settled) |-> sig_q[MAN_W]);
endmodule

// File: tb/fp_addsub_bench.sv
module fp_addsub_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic sub_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] result_o;
  logic ovf_o, unf_o, done_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [W-1:0] got_res;
  logic got_ovf, got_unf;

  always #10 clk = ~clk;   // 50 MHz

  fp_addsub u_fp_addsub (
    .clk(clk), .rst(rst), .start_i(start_i), .sub_i(sub_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // arithmetic model: returns {unf, ovf, result}
  function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic op);
    longint ea, eb, ma, mb, mL, mS, eL, d, s, e;
    logic sa, sb, sL, swap;
    ea = longint'(a[30:23]);
    eb = longint'(b[30:23]);
    sa = a[31];
    sb = b[31] ^ op;
    if (ea == 0) return {2'b00, sb, b[30:0]};
    if (eb == 0) return {2'b00, a};
    ma = longint'({1'b1, a[22:0]});
    mb = longint'({1'b1, b[22:0]});
    swap = (ea < eb) || ((ea == eb) && (ma < mb));
    mL = swap ? mb : ma;
    mS = swap ? ma : mb;
    eL = swap ? eb : ea;
    sL = swap ? sb : sa;
    d = swap ? (eb - ea) : (ea - eb);
    if (d >= 24) mS = 0;
    else mS = mS >> d;
    s = (sa != sb) ? (mL - mS) : (mL + mS);
    if (s == 0) return '0;
    e = eL;
    if (s >= (64'd1 << 24)) begin
      s = s >> 1;
      e = e + 1;
    end
    while (s < (64'd1 << 23)) begin
      s = s << 1;
      e = e - 1;
    end
    if (e >= 255) return {2'b01, 32'h0};
    if (e < 1) return {2'b10, 32'h0};
    return {2'b00, sL, e[7:0], s[22:0]};
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic op);
    int waited;
    @(negedge clk);
    a_i = a;
    b_i = b;
    sub_i = op;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (!done_o && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    if (!done_o) begin
      total++;
      bad++;
      $display("FAIL R11: actual=no done expected=done");
    end
    got_res = result_o;
    got_ovf = ovf_o;
    got_unf = unf_o;
  endtask

  task automatic check(input string tag, input logic [W+1:0] act, input logic [W+1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic directed(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic op, input logic [W+1:0] exp);
    run_op(a, b, op);
    check(tag, {got_unf, got_ovf, got_res}, exp);
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {unf_o, ovf_o, result_o}, '0);
    check("R1 done", {33'b0, done_o}, '0);
    rst = 1'b0;

    directed("R2 2^23+1", 32'h4b000000, 32'h3f800000, 1'b0, {2'b00, 32'h4b000001});
    directed("R3 shift 24", 32'h4b800000, 32'h3f800000, 1'b0, {2'b00, 32'h4b800000});
    directed("R3 shift big", 32'h3f800000, 32'h7f000000, 1'b0, {2'b00, 32'h7f000000});
    directed("R5 carry", 32'h3f800000, 32'h3f800000, 1'b0, {2'b00, 32'h40000000});
    directed("R5 truncate", 32'h3f800001, 32'h3f800000, 1'b0, {2'b00, 32'h40000000});
    directed("R4 larger B", 32'h3f800000, 32'h40400000, 1'b1, {2'b00, 32'hc0000000});
    directed("R4 sub neg", 32'h3f800000, 32'hbf800000, 1'b1, {2'b00, 32'h40000000});
    directed("R6 leading zeros", 32'h3f800000, 32'h3f400000, 1'b1, {2'b00, 32'h3e800000});
    directed("R7 cancel sub", 32'h40490fdb, 32'h40490fdb, 1'b1, '0);
    directed("R7 cancel add", 32'hc1234567, 32'h41234567, 1'b0, '0);
    directed("R8 zero A", 32'h00000000, 32'h40400000, 1'b1, {2'b00, 32'hc0400000});
    directed("R8 zero B", 32'hc1200000, 32'h80000000, 1'b0, {2'b00, 32'hc1200000});
    directed("R8 zero frac ignored", 32'h40a00000, 32'h007fffff, 1'b1, {2'b00, 32'h40a00000});
    directed("R9 overflow", 32'h7f7fffff, 32'h7f7fffff, 1'b0, {2'b01, 32'h0});
    directed("R10 underflow", 32'h00c00000, 32'h00800000, 1'b1, {2'b10, 32'h0});

    // R11: one-cycle strobe, then the result holds
    run_op(32'h40000000, 32'h40000000, 1'b0);
    held = got_res;
    @(negedge clk);
    check("R11 pulse", {33'b0, done_o}, '0);
    repeat (5) @(negedge clk);
    check("R11 hold", {2'b00, result_o}, {2'b00, held});
    check("R11 value", {2'b00, held}, {2'b00, 32'h40800000});

    // sweep: nearby exponents exercise alignment, add and subtract paths
    for (int i = 0; i < 2500; i++) begin
      logic [W-1:0] a, b;
      logic op;
      logic [W+1:0] exp;
      a = $urandom;
      b = $urandom;
      op = 1'($urandom);
      a[30:23] = 8'(100 + ($urandom % 40));
      b[30:23] = (i % 4 == 0) ? 8'($urandom) : 8'(100 + ($urandom % 40));
      exp = model(a, b, op);
      run_op(a, b, op);
      check(((a[31] ^ b[31] ^ op) != 1'b0) ? "R4 sweep" : "R2 sweep",
            {got_unf, got_ovf, got_res}, exp);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule